// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches the divided reference and the divided feedback, turns each pair of rising edges into UP and DOWN pulses with a small phase-frequency detector model, and measures how long exactly one of the two pulses is high. That time, counted in cycles of a fast sampling clock, is the phase error of one phase-detector cycle.

The block closes the measurement once per detector cycle, when both pulses have cleared after their common overlap. A hysteresis stage then updates an active-high lock flag. The flag sets only after a run of consecutive small-error cycles. Once set, it clears on any single cycle whose error exceeds a second, larger limit. Errors between the two limits hold the flag while locked, but break the run while unlocked.

The power-down control drives the synchronous reset, which returns the detector, the meter and the flag to their idle state. All inputs are assumed to be synchronous to the sampling clock.

Top module: `pll_lock_monitor`

## Requirements
- R1: A rising edge on `ref_in` sets `pfd_up`, and a rising edge on `fb_in` sets `pfd_dn`, each at the first sampling-clock edge that sees the input high.
- R2: Once `pfd_up` and `pfd_dn` are both high, both stay high for exactly OVERLAP sampling cycles and then clear together.
- R3: `phase_err` reports the number of sampling cycles in one detector cycle during which exactly one of `pfd_up`/`pfd_dn` was high, saturated at 2^ERR_W-1. `phase_err_vld` is a one-cycle pulse issued one cycle after both pulses have cleared. `phase_err` holds its value until the next pulse.
- R4: While unlocked, `locked` rises after GOOD_RUN consecutive measurements with `phase_err` < SET_LIMIT.
- R5: While unlocked, a measurement with `phase_err` >= SET_LIMIT restarts the consecutive count from zero.
- R6: While locked, a measurement with `phase_err` <= CLR_LIMIT keeps `locked` high, and a measurement with `phase_err` > CLR_LIMIT drops it.
- R7: While `rst_n` is low at a clock edge, `locked`, `pfd_up`, `pfd_dn`, `phase_err_vld` and `phase_err` are all 0 after that edge, and any partial run of good measurements is discarded.
- R8: `locked` changes only in the cycle after a `phase_err_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset, driven by power-down |
| ref_in | input | 1 | Divided reference, synchronous to clk |
| fb_in | input | 1 | Divided feedback, synchronous to clk |
| pfd_up | output | 1 | Detector UP pulse |
| pfd_dn | output | 1 | Detector DOWN pulse |
| phase_err | output | ERR_W | Last measured phase error in sampling cycles |
| phase_err_vld | output | 1 | One-cycle pulse: new phase error available |
| locked | output | 1 | Active-high lock flag |

## Verification
The bench builds the block with SET_LIMIT=4, CLR_LIMIT=7, GOOD_RUN=3, OVERLAP=2 and ERR_W=4. With these values every skew from -20 to +20 sampling cycles can be swept in one run. That range covers both pulse orders, zero skew, each side of both thresholds and the saturation of the error field. The sweep order itself drives the flag through setting, holding in the band between the limits, and clearing. Dedicated sequences break a good run with a mid-band error, and assert reset while the flag is high.

// File: rtl/lkd_pkg.sv
// Shared types for the lock detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lkd_pkg;
    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_HELD   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/lkd_pfd.sv
// Three-state phase-frequency detector model in the sampling-clock domain.
// A rising edge on ref_in sets up, a rising edge on fb_in sets dn. When both
// are high they stay high for OVERLAP cycles (anti-backlash), then clear.
// Assumes: inputs synchronous to clk; OVERLAP >= 1.
module lkd_pfd #(
    parameter int OVERLAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic up,
    output logic dn
);
    localparam int OV_W = $clog2(OVERLAP + 1);
    localparam logic [OV_W-1:0] OV_LAST = OV_W'(OVERLAP - 1);

    logic            ref_q, fb_q;
    logic            ref_rise, fb_rise;
    logic            both, clr;
    logic [OV_W-1:0] ov_cnt;

    assign ref_rise = ref_in & ~ref_q;
    assign fb_rise  = fb_in & ~fb_q;
    assign both     = up & dn;
    assign clr      = both && (ov_cnt == OV_LAST);

    // Remember last input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            fb_q  <= 1'b0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
        end
    end

    // Set pulses on edges, clear both after the overlap; a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= (up & ~clr) | ref_rise;
            dn <= (dn & ~clr) | fb_rise;
        end
    end

    // Count cycles of overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_cnt <= '0;
        end else if (both && !clr) begin
            ov_cnt <= ov_cnt + 1'b1;
        end else begin
            ov_cnt <= '0;
        end
    end

    // R1: an edge always raises its pulse.
    a_r1_up_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> up);
    a_r1_dn_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rise |=> dn);
    // R2: overlap ends with both pulses low unless a new edge arrives.
    a_r2_overlap_end: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ref_rise && !fb_rise) |=> (!up && !dn));
    a_r2_overlap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (both && !clr) |=> (up && dn));
endmodule

// File: rtl/lkd_err_meter.sv
// Phase-error meter: counts cycles where exactly one pulse is high and
// closes the measurement when both pulses have fallen.
// Assumes: pulses come from lkd_pfd, which clears them together.
module lkd_err_meter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             dn,
    output logic [ERR_W-1:0] err,
    output logic             vld
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic             any_now, any_q, close;
    logic [ERR_W-1:0] acc;

    assign any_now = up | dn;
    assign close   = any_q & ~any_now;

    // Track activity of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) any_q <= 1'b0;
        else        any_q <= any_now;
    end

    // Accumulate single-pulse cycles, saturating; restart on close.
    always_ff @(posedge clk) begin
        if (!rst_n || close) begin
            acc <= '0;
        end else if ((up ^ dn) && (acc != ERR_MAX)) begin
            acc <= acc + 1'b1;
        end
    end

    // Publish the result once per detector cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= '0;
            vld <= 1'b0;
        end else begin
            vld <= close;
            if (close) err <= acc;
        end
    end

    // R3: single-cycle valid that follows an idle cycle of both pulses.
    a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    a_r3_vld_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(!(up | dn)));
    a_r3_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(err));
endmodule

// File: rtl/lkd_hyst.sv
// Lock decision with hysteresis: GOOD_RUN consecutive errors below SET_LIMIT
// set the flag; one error above CLR_LIMIT clears it.
// Assumes: CLR_LIMIT >= SET_LIMIT; GOOD_RUN >= 1.
module lkd_hyst
    import lkd_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int SET_LIMIT = 15,
    parameter int CLR_LIMIT = 25,
    parameter int GOOD_RUN  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err,
    input  logic             vld,
    output logic             locked
);
    localparam int RUN_W = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);
    localparam logic [ERR_W-1:0] SET_L = ERR_W'(SET_LIMIT);
    localparam logic [ERR_W-1:0] CLR_L = ERR_W'(CLR_LIMIT);

    lock_state_t      state;
    logic [RUN_W-1:0] run;
    logic             small_err, big_err;

    assign small_err = err < SET_L;
    assign big_err   = err > CLR_L;
    assign locked    = (state == LK_HELD);

    // Update run and lock state on each finished measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_SEARCH;
            run   <= '0;
        end else if (vld) begin
            case (state)
                LK_SEARCH: begin
                    if (!small_err) begin
                        run <= '0;
                    end else if (run == RUN_LAST) begin
                        run   <= '0;
                        state <= LK_HELD;
                    end else begin
                        run <= run + 1'b1;
                    end
                end
                default: begin
                    if (big_err) begin
                        state <= LK_SEARCH;
                        run   <= '0;
                    end
                end
            endcase
        end
    end

    // R8: flag moves only after a measurement.
    a_r8_stable_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(locked));
    // R6: large error drops lock, non-large error keeps it.
    a_r6_clear_big: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && locked && big_err) |=> !locked);
    a_r6_keep_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && locked && !big_err) |=> locked);
    // R5: a non-small error while searching leaves the flag low.
    a_r5_no_set_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !locked && !small_err) |=> !locked);
    // R4: final good measurement of the run sets the flag.
    a_r4_set_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !locked && small_err && run == RUN_LAST) |=> locked);
endmodule

// File: rtl/pll_lock_monitor.sv
// Top of the digital lock detector: PFD model, phase-error meter and
// hysteresis stage in one sampling-clock domain.
// Assumes: ref_in/fb_in synchronous to clk; rst_n driven by power-down.
module pll_lock_monitor #(
    parameter int ERR_W     = 8,
    parameter int SET_LIMIT = 15,
    parameter int CLR_LIMIT = 25,
    parameter int GOOD_RUN  = 3,
    parameter int OVERLAP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             pfd_up,
    output logic             pfd_dn,
    output logic [ERR_W-1:0] phase_err,
    output logic             phase_err_vld,
    output logic             locked
);
    lkd_pfd #(.OVERLAP(OVERLAP)) i_pfd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .up     (pfd_up),
        .dn     (pfd_dn)
    );

    lkd_err_meter #(.ERR_W(ERR_W)) i_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (pfd_up),
        .dn    (pfd_dn),
        .err   (phase_err),
        .vld   (phase_err_vld)
    );

    lkd_hyst #(
        .ERR_W     (ERR_W),
        .SET_LIMIT (SET_LIMIT),
        .CLR_LIMIT (CLR_LIMIT),
        .GOOD_RUN  (GOOD_RUN)
    ) i_hyst (
        .clk    (clk),
        .rst_n  (rst_n),
        .err    (phase_err),
        .vld    (phase_err_vld),
        .locked (locked)
    );
endmodule

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;
    localparam int ERR_W = 4;
    localparam int SETL  = 4;
    localparam int CLRL  = 7;
    localparam int RUNN  = 3;
    localparam int OVL   = 2;
    localparam int EMAX  = (1 << ERR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic pfd_up, pfd_dn, phase_err_vld, locked;
    logic [ERR_W-1:0] phase_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int m_run = 0;
    bit m_lock = 1'b0;

    always #5 clk = ~clk;

    pll_lock_monitor #(
        .ERR_W(ERR_W), .SET_LIMIT(SETL), .CLR_LIMIT(CLRL),
        .GOOD_RUN(RUNN), .OVERLAP(OVL)
    ) i_pll_lock_monitor (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pfd_up(pfd_up), .pfd_dn(pfd_dn), .phase_err(phase_err),
        .phase_err_vld(phase_err_vld), .locked(locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of the hysteresis from R4/R5/R6.
    task automatic model_step(input int e);
        if (!m_lock) begin
            if (e < SETL) begin
                m_run++;
                if (m_run == RUNN) begin
                    m_lock = 1'b1;
                    m_run = 0;
                end
            end else begin
                m_run = 0;
            end
        end else if (e > CLRL) begin
            m_lock = 1'b0;
        end
    endtask

    // One detector cycle; s>0: reference leads by s, s<0: feedback leads.
    task automatic pfd_cycle(input int s);
        int mag, both_cnt, exp_err, total;
        bit lock_before;
        mag = (s < 0) ? -s : s;
        both_cnt = 0;
        total = mag + OVL + 8;
        exp_err = (mag > EMAX) ? EMAX : mag;
        lock_before = m_lock;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            if (k >= 1) begin
                if (pfd_up && pfd_dn) both_cnt++;
                if (k == 1 && mag >= 1) begin
                    check("R1 lead pulse up", int'(pfd_up), (s > 0) ? 1 : 0);
                    check("R1 lead pulse dn", int'(pfd_dn), (s < 0) ? 1 : 0);
                end
                if (k >= 1 && k < mag + OVL + 2)
                    check("R8 lock steady mid-cycle", int'(locked), int'(lock_before));
            end
            if (k == 0) begin
                if (s >= 0) ref_in = 1'b1;
                if (s <= 0) fb_in = 1'b1;
            end
            if (k == mag && mag != 0) begin
                ref_in = 1'b1;
                fb_in = 1'b1;
            end
            if (k == mag + OVL + 4) begin
                ref_in = 1'b0;
                fb_in = 1'b0;
            end
        end
        model_step(exp_err);
        check("R2 overlap cycles", both_cnt, OVL);
        check("R3 phase error", int'(phase_err), exp_err);
        check("R4/R5/R6 lock flag", int'(locked), int'(m_lock));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_run = 0;
        m_lock = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset locked", int'(locked), 0);
        check("R7 reset up", int'(pfd_up), 0);
        check("R7 reset dn", int'(pfd_dn), 0);
        check("R7 reset err", int'(phase_err), 0);
        check("R7 reset vld", int'(phase_err_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of all skews: sets, holds in the band, clears, saturates (R3).
        for (int s = -20; s <= 20; s++) pfd_cycle(s);

        // R5: a mid-band error breaks the run while unlocked.
        do_reset();
        pfd_cycle(1); pfd_cycle(2);
        pfd_cycle(5);
        check("R5 run broken", int'(locked), 0);
        pfd_cycle(0); pfd_cycle(-3);
        check("R5 two after break", int'(locked), 0);
        pfd_cycle(3);
        check("R4 set after full run", int'(locked), 1);

        // R6: upper boundary holds, one above clears.
        pfd_cycle(CLRL);
        check("R6 hold at limit", int'(locked), 1);
        pfd_cycle(-(CLRL + 1));
        check("R6 clear above limit", int'(locked), 0);

        // R7: reset while locked, and reset discards a partial run.
        pfd_cycle(0); pfd_cycle(0); pfd_cycle(0);
        check("R4 relock", int'(locked), 1);
        do_reset();
        check("R7 reset drops lock", int'(locked), 0);
        pfd_cycle(1); pfd_cycle(1);
        do_reset();
        pfd_cycle(1);
        check("R7 run discarded", int'(locked), 0);
        pfd_cycle(1); pfd_cycle(1);
        check("R4 lock after fresh run", int'(locked), 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule